// File: doc/BRIEF.md
# BCD Calendar Real-Time Counter

This block keeps time of day and calendar date in packed BCD counters. A reference tick input, one cycle wide at a rate of 2^DIV_W pulses per second, steps a prescaler. The prescaler is visible as a binary sub-second counter, and each time it wraps the seconds count advances. The advance ripples through minutes, hours, day of week, day of month, month and a four-digit year. Month length and the leap-year rules are applied to the full year.

Software reaches the block through a sixteen-word register port with a write strobe and a combinational read. Counting is gated by an enable bit and a start bit. The time fields can be loaded only while start is 0. The prescaler can be cleared by a self-clearing command, and a 30-second adjust command rounds the seconds to a whole minute.

A sticky carry flag lets a reader detect a seconds tick that lands between the reads of a multi-register snapshot: clear the flag, read the fields, re-check the flag, and repeat if it is set. A second sticky flag is raised by a periodic event whose rate is selectable. Each flag has an interrupt output.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, control word 1 and control word 2 read 0x0000, and both interrupt outputs are low. The time reads 2000-01-01 00:00:00 with day of week 0 (year word 0x2000, month word 0x01, day word 0x01, other fields 0x00).
- R2: Word map: 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 day of month, 6 month (1 to 12), 7 year, 14 control 1, 15 control 2. Time fields are packed BCD in bits 7:0, except the year, which uses bits 15:0 (century in bits 15:8, year within the century in bits 7:0). Writes to words 1 to 7 load the field while start is 0 and are ignored while start is 1.
- R3: The sub-second word reads the binary prescaler count in its low DIV_W bits. The count advances once per reference tick only while both control 2 bit 3 (enable) and bit 0 (start) are 1, and otherwise holds. Writing control 2 with bit 1 set clears it to 0. Bit 1 always reads 0.
- R4: When a tick arrives with the prescaler at its all-ones value, the seconds advance. The counters roll over in BCD: seconds 59 to 00 carries into minutes, minutes 59 to 00 into hours, hours 23 to 00 into the day. Day of week wraps from 6 to 0.
- R5: Day of month rolls to 01 after the last day of the month: 28 or 29 for February, 30 for April, June, September and November, 31 otherwise. A year is a leap year when it is divisible by 4 and not by 100, or when it is divisible by 400. Month 12 rolls to 01, and the year increments in BCD through the century, with 9999 wrapping to 0000.
- R6: Control 1 bit 7 is the carry flag. It sets on every seconds update, whether from counting or from an adjust. Writing 0 to the bit clears it, and writing 1 has no effect. If a set and a clear fall in the same cycle, the flag stays set.
- R7: The carry interrupt output equals carry flag AND control 1 bit 4.
- R8: Control 2 bits 6:4 select the periodic rate: 1 gives 256 Hz (every tick), 2 gives 64 Hz, 3 gives 16 Hz, 4 gives 4 Hz, 5 gives 1 Hz, and 0, 6 and 7 give no events. An event sets the sticky flag in control 2 bit 7. Writing 0 to that bit clears it, and writing 1 has no effect. The periodic interrupt output follows the flag.
- R9: Writing control 2 with bit 2 set performs a 30-second adjust, whether the counter is running or stopped. Seconds 30 to 59 become 00 and carry into minutes; seconds 00 to 29 become 00 with no carry. The prescaler clears, the bit reads back 0, and the carry flag sets.
- R10: Control 1 reads {8'h00, flag, 2'b00, carry enable, 4'b0000}. Control 2 reads {8'h00, periodic flag, rate, enable, 1'b0, 1'b0, start}. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Reference tick, one pulse per 1/2^DIV_W second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational on addr_i) |
| carry_irq_o | output | 1 | Carry interrupt request |
| periodic_irq_o | output | 1 | Periodic interrupt request |

## Verification
A seconds tick from the prescaler and a software clear of the carry flag can land on the same clock edge. The bench provokes this by running the prescaler to its all-ones value, then raising the tick together with a control 1 write of bit 7 = 0 in one cycle. The flag must survive, and the interrupt must stay asserted, while the seconds have advanced. A clear one cycle later must succeed. The adjust command can also coincide with a pending tick; it then wins and clears the prescaler, a case checked through the sub-second word.

// File: rtl/rtc_pkg.sv
// Package: shared types, register indices and BCD helpers for the BCD
// real-time counter. Assumes every field value is valid packed BCD.
package rtc_pkg;

    localparam int REG_ADDR_W = 4;
    localparam int SEL_W      = 3;

    localparam logic [REG_ADDR_W-1:0] IDX_SUBSEC = 4'd0;
    localparam logic [REG_ADDR_W-1:0] IDX_SEC    = 4'd1;
    localparam logic [REG_ADDR_W-1:0] IDX_MIN    = 4'd2;
    localparam logic [REG_ADDR_W-1:0] IDX_HOUR   = 4'd3;
    localparam logic [REG_ADDR_W-1:0] IDX_WDAY   = 4'd4;
    localparam logic [REG_ADDR_W-1:0] IDX_MDAY   = 4'd5;
    localparam logic [REG_ADDR_W-1:0] IDX_MON    = 4'd6;
    localparam logic [REG_ADDR_W-1:0] IDX_YEAR   = 4'd7;
    localparam logic [REG_ADDR_W-1:0] IDX_CTRL1  = 4'd14;
    localparam logic [REG_ADDR_W-1:0] IDX_CTRL2  = 4'd15;

    localparam logic [SEL_W-1:0] SEL_FASTEST = 3'd1;
    localparam logic [SEL_W-1:0] SEL_SLOWEST = 3'd5;

    typedef struct packed {
        logic [15:0] year;
        logic [7:0]  mon;
        logic [7:0]  mday;
        logic [7:0]  wday;
        logic [7:0]  hour;
        logic [7:0]  minute;
        logic [7:0]  sec;
    } rtc_time_t;

    // Increment a two-digit BCD value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Convert a two-digit BCD value to binary.
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

    // Last day of a month, as BCD, using the four-digit BCD year.
    function automatic logic [7:0] last_day(input logic [7:0] mon,
                                            input logic [15:0] year);
        logic leap;
        logic [7:0] yy;
        logic [7:0] cc;
        yy = bcd_to_bin(year[7:0]);
        cc = bcd_to_bin(year[15:8]);
        leap = (yy != 8'd0) ? (yy[1:0] == 2'b00) : (cc[1:0] == 2'b00);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Divides the reference tick into seconds and periodic events.
// Assumes tick_i is a single-cycle pulse; clr_i wins over counting.
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [DIV_W-1:0] count_o,
    output logic             sec_evt_o,
    output logic             per_evt_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_nxt;
    logic [DIV_W-1:0] per_mask;
    logic             step;
    logic             sel_ok;

    assign step    = run_i && tick_i && !clr_i;
    assign cnt_nxt = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};

    // Prescaler count register: clear, advance on tick, or hold.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (step)   cnt_q <= cnt_nxt;
    end

    // Build the low-bit mask whose zero crossing marks a periodic event.
    always_comb begin
        int sh;
        sel_ok = (sel_i >= SEL_FASTEST) && (sel_i <= SEL_SLOWEST);
        sh     = sel_ok ? 2 * (int'(sel_i) - 1) : 0;
        if (sh > DIV_W) sh = DIV_W;
        for (int i = 0; i < DIV_W; i++) per_mask[i] = (i < sh);
    end

    assign count_o   = cnt_q;
    assign sec_evt_o = step && (cnt_q == '1);
    assign per_evt_o = step && sel_ok && ((cnt_nxt & per_mask) == '0);

endmodule

// File: rtl/rtc_calendar.sv
// Module: rtc_calendar
// Holds the BCD time fields, applies second ticks, 30-second adjusts and
// software loads. Assumes loads and ticks never coincide (loads need stop).
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sec_evt_i,
    input  logic                  adj_i,
    input  logic                  ld_en_i,
    input  logic [REG_ADDR_W-1:0] ld_idx_i,
    input  logic [15:0]           ld_data_i,
    output rtc_time_t             time_o
);

    rtc_time_t time_q;
    rtc_time_t time_nxt;

    // Compute the next calendar state from tick, adjust or load.
    always_comb begin
        logic min_c, hour_c, day_c, mon_c, year_c;
        time_nxt = time_q;
        min_c  = 1'b0;
        hour_c = 1'b0;
        day_c  = 1'b0;
        mon_c  = 1'b0;
        year_c = 1'b0;
        if (adj_i) begin
            min_c        = (time_q.sec >= 8'h30);
            time_nxt.sec = 8'h00;
        end else if (sec_evt_i) begin
            if (time_q.sec == 8'h59) begin
                time_nxt.sec = 8'h00;
                min_c        = 1'b1;
            end else begin
                time_nxt.sec = bcd_inc(time_q.sec);
            end
        end
        if (min_c) begin
            if (time_q.minute == 8'h59) begin
                time_nxt.minute = 8'h00;
                hour_c          = 1'b1;
            end else begin
                time_nxt.minute = bcd_inc(time_q.minute);
            end
        end
        if (hour_c) begin
            if (time_q.hour == 8'h23) begin
                time_nxt.hour = 8'h00;
                day_c         = 1'b1;
            end else begin
                time_nxt.hour = bcd_inc(time_q.hour);
            end
        end
        if (day_c) begin
            time_nxt.wday = (time_q.wday >= 8'h06) ? 8'h00 : bcd_inc(time_q.wday);
            if (time_q.mday == last_day(time_q.mon, time_q.year)) begin
                time_nxt.mday = 8'h01;
                mon_c         = 1'b1;
            end else begin
                time_nxt.mday = bcd_inc(time_q.mday);
            end
        end
        if (mon_c) begin
            if (time_q.mon == 8'h12) begin
                time_nxt.mon = 8'h01;
                year_c       = 1'b1;
            end else begin
                time_nxt.mon = bcd_inc(time_q.mon);
            end
        end
        if (year_c) begin
            if (time_q.year[7:0] == 8'h99) begin
                time_nxt.year[7:0]  = 8'h00;
                time_nxt.year[15:8] = (time_q.year[15:8] == 8'h99) ? 8'h00
                                                                   : bcd_inc(time_q.year[15:8]);
            end else begin
                time_nxt.year[7:0] = bcd_inc(time_q.year[7:0]);
            end
        end
        if (ld_en_i) begin
            case (ld_idx_i)
                IDX_SEC:  time_nxt.sec    = ld_data_i[7:0];
                IDX_MIN:  time_nxt.minute = ld_data_i[7:0];
                IDX_HOUR: time_nxt.hour   = ld_data_i[7:0];
                IDX_WDAY: time_nxt.wday   = ld_data_i[7:0];
                IDX_MDAY: time_nxt.mday   = ld_data_i[7:0];
                IDX_MON:  time_nxt.mon    = ld_data_i[7:0];
                IDX_YEAR: time_nxt.year   = ld_data_i;
                default:  ;
            endcase
        end
    end

    // Time field registers with the calendar reset value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            time_q        <= '0;
            time_q.year   <= 16'h2000;
            time_q.mon    <= 8'h01;
            time_q.mday   <= 8'h01;
        end else begin
            time_q <= time_nxt;
        end
    end

    assign time_o = time_q;

endmodule

// File: rtl/rtc_ctrl.sv
// Module: rtc_ctrl
// Control words and sticky event flags. A hardware set wins over a
// software clear in the same cycle; writing 1 to a flag does nothing.
module rtc_ctrl
    import rtc_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [7:0]            wdata_i,
    input  logic                  sec_evt_i,
    input  logic                  per_evt_i,
    output logic                  cf_o,
    output logic                  cie_o,
    output logic                  pef_o,
    output logic [SEL_W-1:0]      sel_o,
    output logic                  en_o,
    output logic                  start_o,
    output logic                  clr_o,
    output logic                  adj_o
);

    logic wr_c1;
    logic wr_c2;

    assign wr_c1 = wr_en_i && (addr_i == IDX_CTRL1);
    assign wr_c2 = wr_en_i && (addr_i == IDX_CTRL2);
    assign adj_o = wr_c2 && wdata_i[2];
    assign clr_o = wr_c2 && (wdata_i[1] || wdata_i[2]);

    // Carry flag: set on seconds update, clear only by writing 0.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        cf_o <= 1'b0;
        else if (sec_evt_i || adj_o)        cf_o <= 1'b1;
        else if (wr_c1 && !wdata_i[7])      cf_o <= 1'b0;
    end

    // Periodic flag: set on periodic event, clear only by writing 0.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        pef_o <= 1'b0;
        else if (per_evt_i)                 pef_o <= 1'b1;
        else if (wr_c2 && !wdata_i[7])      pef_o <= 1'b0;
    end

    // Carry interrupt enable storage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    cie_o <= 1'b0;
        else if (wr_c1) cie_o <= wdata_i[4];
    end

    // Rate select, enable and start storage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sel_o   <= '0;
            en_o    <= 1'b0;
            start_o <= 1'b0;
        end else if (wr_c2) begin
            sel_o   <= wdata_i[6:4];
            en_o    <= wdata_i[3];
            start_o <= wdata_i[0];
        end
    end

endmodule

// File: rtl/rtc_bcd_core.sv
// Module: rtc_bcd_core (top)
// BCD calendar counter with register port, carry and periodic interrupts.
// Assumes tick_i is synchronous to clk_i and one cycle wide; DIV_W <= 16.
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [3:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        carry_irq_o,
    output logic        periodic_irq_o
);

    logic [DIV_W-1:0] subsec;
    logic             sec_evt;
    logic             per_evt;
    logic             cf, cie, pef, en, start, clr, adj, run, ld_en;
    logic [SEL_W-1:0] sel;
    rtc_time_t        tnow;

    assign run   = en && start;
    assign ld_en = wr_en_i && !start && (addr_i >= IDX_SEC) && (addr_i <= IDX_YEAR);

    rtc_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i[7:0]),
        .sec_evt_i (sec_evt),
        .per_evt_i (per_evt),
        .cf_o      (cf),
        .cie_o     (cie),
        .pef_o     (pef),
        .sel_o     (sel),
        .en_o      (en),
        .start_o   (start),
        .clr_o     (clr),
        .adj_o     (adj)
    );

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .tick_i    (tick_i),
        .clr_i     (clr),
        .sel_i     (sel),
        .count_o   (subsec),
        .sec_evt_o (sec_evt),
        .per_evt_o (per_evt)
    );

    rtc_calendar u_cal (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sec_evt_i (sec_evt),
        .adj_i     (adj),
        .ld_en_i   (ld_en),
        .ld_idx_i  (addr_i),
        .ld_data_i (wdata_i),
        .time_o    (tnow)
    );

    // Combinational register read multiplexer.
    always_comb begin
        case (addr_i)
            IDX_SUBSEC: rdata_o = 16'(subsec);
            IDX_SEC:    rdata_o = {8'h00, tnow.sec};
            IDX_MIN:    rdata_o = {8'h00, tnow.minute};
            IDX_HOUR:   rdata_o = {8'h00, tnow.hour};
            IDX_WDAY:   rdata_o = {8'h00, tnow.wday};
            IDX_MDAY:   rdata_o = {8'h00, tnow.mday};
            IDX_MON:    rdata_o = {8'h00, tnow.mon};
            IDX_YEAR:   rdata_o = tnow.year;
            IDX_CTRL1:  rdata_o = {8'h00, cf, 2'b00, cie, 4'b0000};
            IDX_CTRL2:  rdata_o = {8'h00, pef, sel, en, 1'b0, 1'b0, start};
            default:    rdata_o = 16'h0000;
        endcase
    end

    assign carry_irq_o    = cf && cie;
    assign periodic_irq_o = pef;

endmodule

// File: rtl/rtc_bcd_core_sva.sv
// Module: rtc_bcd_core_sva
// Temporal checks on the counter, bound into rtc_bcd_core.
module rtc_bcd_core_sva #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic [3:0]       addr,
    input logic [15:0]      wdata,
    input logic [DIV_W-1:0] subsec,
    input logic [7:0]       sec,
    input logic             cf,
    input logic             pef,
    input logic             run,
    input logic             start
);

    logic c2_clr;
    assign c2_clr = wr_en && (addr == 4'd15) && (wdata[1] || wdata[2]);

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> ($stable(subsec) && $stable(sec))); // R3

    AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd15 && wdata[1]) |=> (subsec == '0)); // R3

    AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !wr_en && subsec == '1) |=> (sec != $past(sec))); // R4

    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !tick && wr_en && addr == 4'd1) |=> $stable(sec)); // R2

    AST_CF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cf && !(wr_en && addr == 4'd14 && !wdata[7])) |=> cf); // R6

    AST_CF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && subsec == '1 && !c2_clr) |=> cf); // R6

    AST_PEF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pef && !(wr_en && addr == 4'd15 && !wdata[7])) |=> pef); // R8

endmodule

bind rtc_bcd_core rtc_bcd_core_sva #(.DIV_W(DIV_W)) sva_i (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .tick   (tick_i),
    .wr_en  (wr_en_i),
    .addr   (addr_i),
    .wdata  (wdata_i),
    .subsec (subsec),
    .sec    (tnow.sec),
    .cf     (cf),
    .pef    (pef),
    .run    (run),
    .start  (start)
);

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        carry_irq;
    logic        periodic_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_s, m_mi, m_h, m_wd, m_md, m_mo, m_y;

    always #2 clk = ~clk;

    rtc_bcd_core dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .tick_i         (tick),
        .wr_en_i        (wr_en),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .carry_irq_o    (carry_irq),
        .periodic_irq_o (periodic_irq)
    );

    function automatic logic [7:0] bcd8(input int v);
        logic [7:0] r;
        r[7:4] = 4'(v / 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    function automatic int dim(input int mo, input int y);
        bit leap;
        leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic m_next_min();
        if (m_mi < 59) begin m_mi++; return; end
        m_mi = 0;
        if (m_h < 23) begin m_h++; return; end
        m_h = 0;
        m_wd = (m_wd + 1) % 7;
        if (m_md < dim(m_mo, m_y)) begin m_md++; return; end
        m_md = 1;
        if (m_mo < 12) begin m_mo++; return; end
        m_mo = 1;
        m_y = (m_y + 1) % 10000;
    endtask

    task automatic m_tick();
        if (m_s == 59) begin m_s = 0; m_next_min(); end
        else m_s++;
    endtask

    task automatic m_adjust();
        if (m_s >= 30) m_next_min();
        m_s = 0;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'd0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        addr = 4'(a);
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_model();
        wr(1, {8'h00, bcd8(m_s)});
        wr(2, {8'h00, bcd8(m_mi)});
        wr(3, {8'h00, bcd8(m_h)});
        wr(4, {8'h00, bcd8(m_wd)});
        wr(5, {8'h00, bcd8(m_md)});
        wr(6, {8'h00, bcd8(m_mo)});
        wr(7, {bcd8(m_y / 100), bcd8(m_y % 100)});
    endtask

    task automatic cmp_time(input string req);
        logic [15:0] d;
        rd(1, d); chk({req, " sec"},  d, {8'h00, bcd8(m_s)});
        rd(2, d); chk({req, " min"},  d, {8'h00, bcd8(m_mi)});
        rd(3, d); chk({req, " hour"}, d, {8'h00, bcd8(m_h)});
        rd(4, d); chk({req, " wday"}, d, {8'h00, bcd8(m_wd)});
        rd(5, d); chk({req, " mday"}, d, {8'h00, bcd8(m_md)});
        rd(6, d); chk({req, " mon"},  d, {8'h00, bcd8(m_mo)});
        rd(7, d); chk({req, " year"}, d, {bcd8(m_y / 100), bcd8(m_y % 100)});
        addr = 4'd0;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] keep;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(14, d); chk("R1 ctrl1", d, 16'h0000);
        rd(15, d); chk("R1 ctrl2", d, 16'h0000);
        chk("R1 carry irq", {15'd0, carry_irq}, 16'd0);
        chk("R1 periodic irq", {15'd0, periodic_irq}, 16'd0);
        m_s = 0; m_mi = 0; m_h = 0; m_wd = 0; m_md = 1; m_mo = 1; m_y = 2000;
        cmp_time("R1");

        // R4 R5: random starting points biased to rollover boundaries
        for (int it = 0; it < 40; it++) begin
            case ($urandom % 6)
                0: m_y = 1999;
                1: m_y = 2000;
                2: m_y = 2100;
                3: m_y = 9999;
                4: m_y = 2024;
                default: m_y = 1900 + int'($urandom % 300);
            endcase
            m_mo = 1 + int'($urandom % 12);
            m_md = ($urandom % 2 == 0) ? dim(m_mo, m_y) : 1 + int'($urandom % dim(m_mo, m_y));
            m_wd = int'($urandom % 7);
            m_h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            m_mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            m_s  = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
            wr(15, 16'h000A);
            load_model();
            cmp_time("R2 load");
            wr(14, 16'h0000);
            wr(15, 16'h0009);
            ticks(256);
            m_tick();
            cmp_time("R4 R5 rollover");
            rd(14, d); chk("R6 carry set", d, 16'h0080);
        end

        // R6 R7: flag set and software clear in the same cycle
        wr(15, 16'h000A);
        m_s = 59; m_mi = 59; m_h = 23; m_wd = 6; m_md = 29; m_mo = 2; m_y = 2000;
        load_model();
        wr(14, 16'h0000);
        wr(15, 16'h0009);
        ticks(255);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 4'd14; wdata = 16'h0010;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; addr = 4'd0;
        m_tick();
        rd(14, d); chk("R6 set wins over clear", d, 16'h0090);
        chk("R7 carry irq on", {15'd0, carry_irq}, 16'd1);
        cmp_time("R5 leap century");
        wr(14, 16'h0010);
        rd(14, d); chk("R6 clear by 0", d, 16'h0010);
        chk("R7 carry irq off", {15'd0, carry_irq}, 16'd0);
        wr(14, 16'h0090);
        rd(14, d); chk("R6 write 1 no effect", d, 16'h0010);
        ticks(256);
        m_tick();
        wr(14, 16'h0080);
        rd(14, d); chk("R10 ctrl1 layout", d, 16'h0080);
        chk("R7 irq masked", {15'd0, carry_irq}, 16'd0);

        // R2: time writes ignored while running
        rd(1, keep);
        wr(1, 16'h0033);
        rd(1, d); chk("R2 write ignored running", d, keep);

        // R3: stopped and disabled hold the counters
        wr(15, 16'h0008);
        rd(0, keep);
        ticks(10);
        rd(0, d); chk("R3 hold start=0", d, keep);
        wr(15, 16'h0001);
        ticks(10);
        rd(0, d); chk("R3 hold en=0", d, keep);
        wr(15, 16'h000A);
        rd(0, d); chk("R3 prescaler clear", d, 16'h0000);
        rd(15, d); chk("R10 ctrl2 rst reads 0", d, 16'h0008);
        wr(15, 16'h000B);
        ticks(37);
        rd(0, d); chk("R3 sub-second count", d, 16'd37);

        // R8: periodic rates
        wr(15, 16'h002B);
        ticks(3);
        chk("R8 64Hz not yet", {15'd0, periodic_irq}, 16'd0);
        ticks(1);
        chk("R8 64Hz event", {15'd0, periodic_irq}, 16'd1);
        rd(15, d); chk("R10 ctrl2 layout", d, 16'h00A9);
        wr(15, 16'h00A9);
        rd(15, d); chk("R8 write 1 no effect", d, 16'h00A9);
        wr(15, 16'h001B);
        chk("R8 cleared", {15'd0, periodic_irq}, 16'd0);
        ticks(1);
        chk("R8 256Hz event", {15'd0, periodic_irq}, 16'd1);
        wr(15, 16'h000B);
        ticks(300);
        chk("R8 code 0 silent", {15'd0, periodic_irq}, 16'd0);
        wr(15, 16'h007B);
        ticks(300);
        chk("R8 code 7 silent", {15'd0, periodic_irq}, 16'd0);
        wr(15, 16'h005B);
        ticks(255);
        chk("R8 1Hz not yet", {15'd0, periodic_irq}, 16'd0);
        ticks(1);
        chk("R8 1Hz event", {15'd0, periodic_irq}, 16'd1);

        // R9: 30-second adjust
        wr(15, 16'h000A);
        m_s = 45; m_mi = 59; m_h = 23; m_wd = 6; m_md = 28; m_mo = 2; m_y = 2023;
        load_model();
        wr(14, 16'h0000);
        wr(15, 16'h000C);
        m_adjust();
        cmp_time("R9 round up");
        rd(14, d); chk("R9 carry set", d, 16'h0080);
        rd(15, d); chk("R9 adj self-clear", d, 16'h0008);
        wr(15, 16'h000A);
        m_s = 29; m_mi = 10; m_h = 5;
        load_model();
        wr(15, 16'h000C);
        m_adjust();
        cmp_time("R9 round down");
        wr(15, 16'h0009);
        ticks(100);
        wr(15, 16'h000D);
        rd(0, d); chk("R9 prescaler cleared", d, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule